// File: doc/BRIEF.md
# PHY Link and Media Setup Sequencer

After the MAC has been reset, this block works out how the attached Ethernet PHY should be configured. It talks to the PHY only through a request/response port that an MDIO master serves. The block issues one register read or write at a time and waits for the matching response pulse before it goes on. A start pulse begins a sequence. When the sequence ends, the block reports three things: a full-duplex flag, an alternate-mode flag (for a PHY running the home-network media type) and a one-cycle done pulse.

In the normal path the block polls the PHY status register until both link bits are set, or until a cycle-count timeout runs out. If the link comes up, it reads the vendor status register to decide duplex. If the link never comes up, it selects the alternate media mode. It then applies identifier-dependent register patches, some of which use read-modify-write arithmetic. When the variant input is set, the block takes a short path instead: it clears register 0 and finishes.

Top module: `phy_media_seq`

## Requirements
- R1: With `simple_mode_i` high at start, the only access is a write of 0x0000 to register 0, and the sequence ends with both flags low.
- R2: On the normal path, register 1 is read again and again until a read returns bits 2 and 5 both set (mask 0x0024). The number of register-1 reads is exactly the number of reads up to and including the first such read.
- R3: If no register-1 read shows both link bits set before `LINK_TIMEOUT_CYC` cycles have passed since start, `alt_mode_o` is set and `full_duplex_o` stays low.
- R4: When the link bits are seen, register 17 is read. `full_duplex_o` is set exactly when (reg17 & 0xA000) != 0, and `alt_mode_o` stays low.
- R5: In alternate mode, patches are written only when (reg3 & 0xFFF0) == 0xB900. Otherwise no write is issued.
- R6: When patching and reg31 == 0x4404, register 16 is written with 0x0005 if reg3 == 0xB901 and with 0x1005 otherwise. Register 25 is then written with ((reg24 + 3) & 0x00FF) | 0xF000.
- R7: When patching and reg31 != 0x4404, register 16 is written with 0x0005. Register 25 is then written with ((reg25 & 0xFF00) + 2), taken modulo 2^16.
- R8: At most one request is outstanding. A new request is issued only after the response to the previous one.
- R9: `done_o` pulses for exactly one cycle per completed sequence. The flags keep their value until the next start.
- R10: A start pulse during a running sequence clears the flags and restarts from the first step. A response still owed to the abandoned request is absorbed and not acted on.
- R11: Out of reset, no request is issued, `done_o` is low and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins (or restarts) a sequence |
| simple_mode_i | input | 1 | Variant select sampled at start: short path |
| req_valid_o | output | 1 | One-cycle request strobe to the MDIO master |
| req_write_o | output | 1 | 1 = register write, 0 = register read |
| req_reg_o | output | REG_AW | PHY register address |
| req_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | Response strobe, one per request |
| rsp_rdata_i | input | DATA_W | Read data returned with the response |
| full_duplex_o | output | 1 | Duplex result |
| alt_mode_o | output | 1 | Alternate media mode selected |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
On every cycle the embedded assertions check that there is never a second outstanding request, that done stays high for only one cycle, that the two flags are never both set, that the short path ends with clear flags, and that the alternate flag rises only after the timeout has expired. The arithmetic of the patch values, the choice between patch branches, the exact number of status polls and the restart behaviour can only be shown by the bench. It sweeps identifier, revision and data values through a register model of the PHY and compares the final register contents with values it computes itself.

// File: rtl/pms_pkg.sv
package pms_pkg;

   localparam int unsigned PMS_DW = 16;

   localparam logic [4:0] RA_CTRL    = 5'd0;
   localparam logic [4:0] RA_STATUS  = 5'd1;
   localparam logic [4:0] RA_ID_REV  = 5'd3;
   localparam logic [4:0] RA_MODE    = 5'd16;
   localparam logic [4:0] RA_VSTAT   = 5'd17;
   localparam logic [4:0] RA_BASE    = 5'd24;
   localparam logic [4:0] RA_TUNE    = 5'd25;
   localparam logic [4:0] RA_VENDOR  = 5'd31;

   localparam logic [15:0] LINK_MASK   = 16'h0024;
   localparam logic [15:0] DUPLEX_MASK = 16'hA000;
   localparam logic [15:0] FAMILY_MASK = 16'hFFF0;
   localparam logic [15:0] FAMILY_ID   = 16'hB900;
   localparam logic [15:0] REV_FIRST   = 16'hB901;
   localparam logic [15:0] VENDOR_SIG  = 16'h4404;

   typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;

   typedef enum logic [3:0] {
      ST_CLR0, ST_LINK, ST_DUPLEX, ST_ID3, ST_ID31,
      ST_W16, ST_RD24, ST_RD25, ST_W25
   } step_e;

   function automatic logic [4:0] step_addr(step_e s);
      case (s)
         ST_CLR0:   step_addr = RA_CTRL;
         ST_LINK:   step_addr = RA_STATUS;
         ST_DUPLEX: step_addr = RA_VSTAT;
         ST_ID3:    step_addr = RA_ID_REV;
         ST_ID31:   step_addr = RA_VENDOR;
         ST_W16:    step_addr = RA_MODE;
         ST_RD24:   step_addr = RA_BASE;
         default:   step_addr = RA_TUNE;
      endcase
   endfunction

   function automatic logic step_writes(step_e s);
      step_writes = (s == ST_CLR0) || (s == ST_W16) || (s == ST_W25);
   endfunction

endpackage

// File: rtl/pms_link_timer.sv
module pms_link_timer #(
   parameter int unsigned LIMIT = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic expired
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   if (LIMIT == 0) begin : g_bad_limit
      $error("pms_link_timer: LIMIT must be at least 1");
   end

   if (LIMIT < 2) begin : g_single
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     hit_q <= 1'b0;
         else if (clear) hit_q <= 1'b0;
         else            hit_q <= 1'b1;
      end
      assign expired = hit_q;
   end else begin : g_count
      localparam logic [CW-1:0] LIM = CW'(LIMIT);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (clear)         cnt_q <= '0;
         else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
      end
      assign expired = (cnt_q == LIM);

      a_r3_timer_saturates: assert property (@(posedge clk) disable iff (!rst_n)
         (expired && !clear) |=> expired);
   end

endmodule

// File: rtl/pms_patch_calc.sv
module pms_patch_calc #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] id_rev,
   input  logic              vendor_hit,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] mode_val,
   output logic [DATA_W-1:0] tune_val
);
   import pms_pkg::*;

   if (DATA_W != PMS_DW) begin : g_bad_width
      $error("pms_patch_calc: DATA_W must be 16");
   end

   logic [DATA_W-1:0] low_sum;

   always_comb begin
      low_sum  = (src + DATA_W'(3)) & DATA_W'(16'h00FF);
      mode_val = (vendor_hit && (id_rev != REV_FIRST)) ? DATA_W'(16'h1005)
                                                        : DATA_W'(16'h0005);
      tune_val = vendor_hit ? (low_sum | DATA_W'(16'hF000))
                            : ((src & DATA_W'(16'hFF00)) + DATA_W'(2));
   end

endmodule

// File: rtl/pms_mdio_port.sv
module pms_mdio_port #(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rsp_valid,
   output logic              req_valid,
   output logic              req_write,
   output logic [REG_AW-1:0] req_reg,
   output logic [DATA_W-1:0] req_wdata,
   output logic              pending
);
   if (REG_AW < 5) begin : g_bad_aw
      $error("pms_mdio_port: REG_AW must cover 32 registers");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_write <= 1'b0;
         req_reg   <= '0;
         req_wdata <= '0;
         pending   <= 1'b0;
      end else begin
         req_valid <= issue;
         if (issue) begin
            req_write <= wr;
            req_reg   <= addr;
            req_wdata <= wdata;
            pending   <= 1'b1;
         end else if (rsp_valid) begin
            pending   <= 1'b0;
         end
      end
   end

   a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !rsp_valid) |-> !issue);
   a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

endmodule

// File: rtl/phy_media_seq.sv
module phy_media_seq #(
   parameter int unsigned REG_AW           = 5,
   parameter int unsigned DATA_W           = 16,
   parameter int unsigned LINK_TIMEOUT_CYC = 50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              simple_mode_i,
   output logic              req_valid_o,
   output logic              req_write_o,
   output logic [REG_AW-1:0] req_reg_o,
   output logic [DATA_W-1:0] req_wdata_o,
   input  logic              rsp_valid_i,
   input  logic [DATA_W-1:0] rsp_rdata_i,
   output logic              full_duplex_o,
   output logic              alt_mode_o,
   output logic              done_o
);
   import pms_pkg::*;

   if (DATA_W != PMS_DW) begin : g_bad_width
      $error("phy_media_seq: DATA_W must be 16");
   end

   phase_e            phase_q;
   step_e             step_q;
   logic [DATA_W-1:0] id_q;
   logic [DATA_W-1:0] src_q;
   logic              vend_q;
   logic              fd_q;
   logic              alt_q;
   logic              done_q;
   logic              short_q;

   logic              pending;
   logic              issue;
   logic              expired;
   logic [DATA_W-1:0] mode_val;
   logic [DATA_W-1:0] tune_val;
   logic [DATA_W-1:0] wdata;
   logic              link_up;
   logic              family_hit;

   assign issue      = (phase_q == PH_ISSUE) && !pending && !start_i;
   assign link_up    = (rsp_rdata_i & LINK_MASK) == LINK_MASK;
   assign family_hit = (rsp_rdata_i & FAMILY_MASK) == FAMILY_ID;

   always_comb begin
      case (step_q)
         ST_W16:  wdata = mode_val;
         ST_W25:  wdata = tune_val;
         default: wdata = '0;
      endcase
   end

   pms_link_timer #(.LIMIT(LINK_TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_i),
      .expired (expired)
   );

   pms_patch_calc #(.DATA_W(DATA_W)) u_patch (
      .id_rev     (id_q),
      .vendor_hit (vend_q),
      .src        (src_q),
      .mode_val   (mode_val),
      .tune_val   (tune_val)
   );

   pms_mdio_port #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .wr        (step_writes(step_q)),
      .addr      (REG_AW'(step_addr(step_q))),
      .wdata     (wdata),
      .rsp_valid (rsp_valid_i),
      .req_valid (req_valid_o),
      .req_write (req_write_o),
      .req_reg   (req_reg_o),
      .req_wdata (req_wdata_o),
      .pending   (pending)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= ST_CLR0;
         id_q    <= '0;
         src_q   <= '0;
         vend_q  <= 1'b0;
         fd_q    <= 1'b0;
         alt_q   <= 1'b0;
         done_q  <= 1'b0;
         short_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            fd_q    <= 1'b0;
            alt_q   <= 1'b0;
            short_q <= simple_mode_i;
            step_q  <= simple_mode_i ? ST_CLR0 : ST_LINK;
            phase_q <= PH_ISSUE;
         end else begin
            case (phase_q)
               PH_ISSUE: if (issue) phase_q <= PH_WAIT;
               PH_WAIT: if (rsp_valid_i) begin
                  phase_q <= PH_ISSUE;
                  case (step_q)
                     ST_CLR0: begin
                        done_q <= 1'b1; phase_q <= PH_IDLE;
                     end
                     ST_LINK: begin
                        if (link_up) step_q <= ST_DUPLEX;
                        else if (expired) begin
                           alt_q  <= 1'b1;
                           step_q <= ST_ID3;
                        end
                     end
                     ST_DUPLEX: begin
                        fd_q   <= |(rsp_rdata_i & DUPLEX_MASK);
                        done_q <= 1'b1; phase_q <= PH_IDLE;
                     end
                     ST_ID3: begin
                        if (family_hit) begin
                           id_q   <= rsp_rdata_i;
                           step_q <= ST_ID31;
                        end else begin
                           done_q <= 1'b1; phase_q <= PH_IDLE;
                        end
                     end
                     ST_ID31: begin
                        vend_q <= (rsp_rdata_i == VENDOR_SIG);
                        step_q <= ST_W16;
                     end
                     ST_W16:  step_q <= vend_q ? ST_RD24 : ST_RD25;
                     ST_RD24, ST_RD25: begin
                        src_q  <= rsp_rdata_i;
                        step_q <= ST_W25;
                     end
                     default: begin
                        done_q <= 1'b1; phase_q <= PH_IDLE;
                     end
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   assign full_duplex_o = fd_q;
   assign alt_mode_o    = alt_q;
   assign done_o        = done_q;

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_duplex_o && alt_mode_o));
   a_r1_short_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && short_q) |-> (!full_duplex_o && !alt_mode_o));
   a_r3_alt_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alt_mode_o) |-> expired);
   a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_IDLE) && !start_i) |=> ($stable(full_duplex_o) && $stable(alt_mode_o)));

endmodule

// File: tb/phy_media_seq_tb.sv
module phy_media_seq_tb;
   localparam int unsigned TMO = 200;
   localparam int unsigned LAT = 3;
   localparam int NEVER = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        simple_mode_i = 1'b0;
   logic        req_valid_o, req_write_o;
   logic [4:0]  req_reg_o;
   logic [15:0] req_wdata_o;
   logic        rsp_valid_i = 1'b0;
   logic [15:0] rsp_rdata_i = '0;
   logic        full_duplex_o, alt_mode_o, done_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   phy_media_seq #(.REG_AW(5), .DATA_W(16), .LINK_TIMEOUT_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .simple_mode_i(simple_mode_i),
      .req_valid_o(req_valid_o), .req_write_o(req_write_o), .req_reg_o(req_reg_o),
      .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i),
      .full_duplex_o(full_duplex_o), .alt_mode_o(alt_mode_o), .done_o(done_o));

   // PHY register model
   logic [15:0] phy [32];
   int          link_after = 0;
   int          st_reads = 0;
   int          n_writes = 0;
   int          proto_err = 0;
   int          done_cnt = 0;
   int          cyc = 0;
   logic        busy = 1'b0;
   int          lat = 0;
   logic        c_wr;
   logic [4:0]  c_reg;
   logic [15:0] c_wd;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done_o) done_cnt <= done_cnt + 1;
      rsp_valid_i <= 1'b0;
      if (busy) begin
         if (lat == 0) begin
            busy <= 1'b0;
            rsp_valid_i <= 1'b1;
            if (c_wr) begin
               phy[c_reg] <= c_wd;
               n_writes <= n_writes + 1;
               rsp_rdata_i <= 16'h0000;
            end else if (c_reg == 5'd1) begin
               rsp_rdata_i <= (st_reads >= link_after) ? (phy[1] | 16'h0024)
                                                       : (phy[1] & ~16'h0024);
               st_reads <= st_reads + 1;
            end else begin
               rsp_rdata_i <= phy[c_reg];
            end
         end else lat <= lat - 1;
      end
      if (req_valid_o) begin
         if (busy) proto_err <= proto_err + 1;
         busy  <= 1'b1;
         lat   <= LAT;
         c_wr  <= req_write_o;
         c_reg <= req_reg_o;
         c_wd  <= req_wdata_o;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic setup(input logic [15:0] r17, input logic [15:0] r3, input logic [15:0] r31,
                        input logic [15:0] r24, input logic [15:0] r25, input int la);
      for (int i = 0; i < 32; i++) phy[i] = 16'(16'h0100 + i);
      phy[0] = 16'h3100; phy[1] = 16'h7809;
      phy[17] = r17; phy[3] = r3; phy[31] = r31; phy[24] = r24; phy[25] = r25;
      link_after = la; st_reads = 0; n_writes = 0;
   endtask

   task automatic pulse_start(input logic simple);
      @(negedge clk);
      simple_mode_i = simple; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // waits for done; returns cycles since call
   task automatic wait_done(output int elapsed, output logic fd, output logic alt);
      int t0;
      t0 = cyc;
      fd = 1'b0; alt = 1'b0;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (done_o) begin
            fd = full_duplex_o; alt = alt_mode_o;
            elapsed = cyc - t0;
            return;
         end
      end
      elapsed = -1;
   endtask

   task automatic run(input logic simple, input int la, input logic [15:0] r17,
                      input logic [15:0] r3, input logic [15:0] r31,
                      input logic [15:0] r24, input logic [15:0] r25);
      int el, d0;
      logic fd, alt;
      logic [15:0] e16, e25;
      logic patch;
      setup(r17, r3, r31, r24, r25, la);
      d0 = done_cnt;
      pulse_start(simple);
      wait_done(el, fd, alt);
      chk("R9 sequence completes", (el >= 0), 1);
      repeat (10) @(negedge clk);
      chk("R9 single done pulse", done_cnt - d0, 1);
      chk("R9 flags held fd", full_duplex_o, fd);
      chk("R9 flags held alt", alt_mode_o, alt);
      if (simple) begin
         chk("R1 reg0 cleared", phy[0], 16'h0000);
         chk("R1 one access", n_writes, 1);
         chk("R1 no status poll", st_reads, 0);
         chk("R1 flags clear", {fd, alt}, 0);
      end else if (la < NEVER) begin
         chk("R2 poll count", st_reads, la + 1);
         chk("R4 duplex", fd, ((r17 & 16'hA000) != 0));
         chk("R4 no alt", alt, 0);
         chk("R4 no writes", n_writes, 0);
      end else begin
         chk("R3 alt set", alt, 1);
         chk("R3 fd clear", fd, 0);
         chk("R3 timeout respected", (el >= int'(TMO)), 1);
         patch = ((r3 & 16'hFFF0) == 16'hB900);
         if (!patch) begin
            chk("R5 no patch writes", n_writes, 0);
         end else if (r31 == 16'h4404) begin
            e16 = (r3 == 16'hB901) ? 16'h0005 : 16'h1005;
            e25 = 16'(((32'(r24) + 3) & 32'hFF) | 32'hF000);
            chk("R5 two writes", n_writes, 2);
            chk("R6 reg16", phy[16], e16);
            chk("R6 reg25", phy[25], e25);
         end else begin
            e25 = 16'((32'(r25) & 32'hFF00) + 2);
            chk("R5 two writes", n_writes, 2);
            chk("R7 reg16", phy[16], 16'h0005);
            chk("R7 reg25", phy[25], e25);
         end
      end
   endtask

   initial begin
      int el, d0;
      logic fd, alt;
      logic [15:0] r17s [4] = '{16'h0000, 16'h8000, 16'h2000, 16'h5FFF};
      logic [15:0] r3s  [5] = '{16'h1234, 16'hB900, 16'hB901, 16'hB90F, 16'hB910};
      logic [15:0] r31s [2] = '{16'h4404, 16'h4405};
      logic [15:0] vals [3] = '{16'h00FD, 16'h12FF, 16'hFFFE};
      for (int i = 0; i < 32; i++) phy[i] = '0;
      repeat (3) @(negedge clk);
      chk("R11 reset req", req_valid_o, 0);
      chk("R11 reset done", done_o, 0);
      chk("R11 reset flags", {full_duplex_o, alt_mode_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R11 idle after reset", {req_valid_o, done_o}, 0);

      run(1'b1, 0, 16'hA000, 16'h0, 16'h0, 16'h0, 16'h0);
      foreach (r17s[a]) for (int la = 0; la < 6; la += 2)
         run(1'b0, la, r17s[a], 16'h0, 16'h0, 16'h0, 16'h0);
      foreach (r3s[a]) foreach (r31s[b]) foreach (vals[c])
         run(1'b0, NEVER, 16'hA000, r3s[a], r31s[b], vals[c], vals[(c + 1) % 3]);
      run(1'b1, 0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);

      // R10: restart mid-poll
      setup(16'h2000, 16'hB900, 16'h4404, 16'h0, 16'h0, NEVER);
      d0 = done_cnt;
      pulse_start(1'b0);
      repeat (30) @(negedge clk);
      link_after = 0;
      pulse_start(1'b0);
      chk("R10 flags cleared on restart", {full_duplex_o, alt_mode_o}, 0);
      wait_done(el, fd, alt);
      chk("R10 restart completes", (el >= 0), 1);
      chk("R10 duplex after restart", fd, 1);
      chk("R10 no alt after restart", alt, 0);
      repeat (10) @(negedge clk);
      chk("R10 one done for two starts", done_cnt - d0, 1);
      chk("R10 no stray writes", n_writes, 0);

      chk("R8 single outstanding", proto_err, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule